// File: doc/BRIEF.md
# Card Command Response Checker

This block supervises the command line of a memory-card host from the moment a command goes out until its response has been judged. It works on card-clock sample enables. On each enable it sees three things: the level the host is putting on the line, whether the host is driving the line at all, and the line level actually sampled. When the host finishes the end bit of a command, it pulses `cmd_sent` and latches the expected command index and the response length. The checker then waits for the card's response start bit. It times out if none arrives within a fixed window, and it walks the response bit by bit to check the transmission bit, the index field and the end bit. A separate receiver computes the CRC7 and supplies a match flag, which is captured when the end bit is sampled.

Whenever the host drives a 1 and the next sample reads 0, another device is fighting for the line. The checker then raises an abort request, so the host stops driving. In the same cycle it reports a line conflict, a timeout and a CRC error, and it drops back to idle. Every report is a single-cycle pulse.

The controller states are IDLE, WAIT (watching for the start bit), HEAD (transmission bit and index field), BODY (payload bits), TAIL (end bit) and REPORT (one cycle to emit the verdict). The transitions are:
- issue: any state goes to WAIT on `cmd_sent`.
- start: WAIT goes to HEAD on the first sampled 0 while the host is released.
- expire: WAIT goes to IDLE after the 64th sample with no start bit.
- head_done: HEAD goes to BODY after the last index bit.
- body_done: BODY goes to TAIL after the second-to-last bit.
- end_seen: TAIL goes to REPORT.
- retire: REPORT goes to IDLE.
- abort: any state goes to IDLE on a conflict. A conflict takes priority over `cmd_sent`, which takes priority over every other transition.

Top module: `cmd_resp_checker`

## Requirements
- R1: After `cmd_sent`, if none of the first 64 sample enables shows a start bit (line 0 with the host released), `err_timeout` pulses once. Its pulse follows the 64th enable. A start bit on the 64th enable prevents the timeout.
- R2: A sample of 0 on the enable after one where the host drove 1 raises `err_conflict`, `err_timeout`, `err_crc` and `abort_req` together for one cycle. The checker then returns to IDLE, and no later timeout follows for that command.
- R3: No conflict is reported when the host drove 0, or did not drive, on the previous enable, whatever the line level.
- R4: For a received response, `err_crc` pulses only if `crc_match` is low when the end bit is sampled. A command that timed out never produces `err_crc`, even when `crc_match` is low.
- R5: `err_endbit` pulses when the last bit of the response (bit 47 of a short response, bit 135 of a long one, with the start bit counted as bit 0) is sampled as 0.
- R6: For a 48-bit response, `err_index` pulses when bits 2 to 7 (sent MSB first) differ from the index latched at `cmd_sent`.
- R7: With `long_resp` set at `cmd_sent`, the response is 136 bits and the index field is not compared.
- R8: A transmission bit (bit 1) of 1 is reported through `err_index`, for either length.
- R9: All outputs are low after reset. Every error output is a single-cycle pulse issued from REPORT, after which the checker is idle and accepts the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One-cycle card-clock sample enable |
| cmd_sent | input | 1 | Pulse: command end bit has been sent |
| drv_en | input | 1 | Host is driving the command line |
| drv_val | input | 1 | Level the host drives |
| line_in | input | 1 | Sampled command line level |
| exp_index | input | IDX_W | Expected response index, latched at `cmd_sent` |
| long_resp | input | 1 | 1 selects a 136-bit response, latched at `cmd_sent` |
| crc_match | input | 1 | CRC7 match flag from the response receiver |
| err_timeout | output | 1 | Timeout pulse |
| err_crc | output | 1 | CRC error pulse |
| err_endbit | output | 1 | End-bit error pulse |
| err_index | output | 1 | Index or transmission-bit error pulse |
| err_conflict | output | 1 | Line conflict pulse |
| abort_req | output | 1 | Pulse: host must stop driving the line |

## Verification
The bench targets the edge of the start-bit window: a start bit on the 64th enable must pass, and a missing one must time out exactly after that enable. A counter that is off by one would time out one enable early or late. Long responses carry a mismatched index and a late 0 end bit, so a design that compares the index for 136-bit responses, or looks for the end bit at the short position, reports the wrong error. The conflict cases check that all four pulses coincide and that no stray timeout follows, which exposes a design that keeps its timer running after an abort. They also check that a timeout with a low CRC flag never reports a CRC error.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        CCR_IDLE,
        CCR_WAIT,
        CCR_HEAD,
        CCR_BODY,
        CCR_TAIL,
        CCR_REPORT
    } ccr_state_e;

    typedef struct packed {
        logic crc;
        logic endbit;
        logic index;
    } ccr_verdict_t;

endpackage

// File: rtl/ccr_conflict_mon.sv
module ccr_conflict_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic flush,
    input  logic drv_en,
    input  logic drv_val,
    input  logic line_in,
    output logic hit
);
    // Remembers whether the host launched a 1 on the previous enable.
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (flush) begin
            armed_q <= 1'b0;
        end else if (smp_en) begin
            armed_q <= drv_en & drv_val;
        end
    end

    assign hit = smp_en & armed_q & ~line_in;
endmodule

// File: rtl/ccr_start_wdog.sv
module ccr_start_wdog #(
    parameter int WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = tick && (cnt_q == LAST);
endmodule

// File: rtl/ccr_field_cap.sv
module ccr_field_cap #(
    parameter int IDX_W = 6,
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic             bit_in,
    output logic [POS_W-1:0] pos,
    output logic [IDX_W-1:0] idx,
    output logic             trans_bit
);
    localparam logic [POS_W-1:0] IDX_FIRST = POS_W'(2);
    localparam logic [POS_W-1:0] IDX_LAST  = POS_W'(IDX_W + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            idx       <= '0;
            trans_bit <= 1'b0;
        end else if (load) begin
            // Start bit counts as position 0; next sample is position 1.
            pos       <= POS_W'(1);
            idx       <= '0;
            trans_bit <= 1'b0;
        end else if (tick) begin
            if (pos == POS_W'(1)) begin
                trans_bit <= bit_in;
            end
            if (pos >= IDX_FIRST && pos <= IDX_LAST) begin
                idx <= {idx[IDX_W-2:0], bit_in};
            end
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/cmd_resp_checker.sv
module cmd_resp_checker
    import ccr_pkg::*;
#(
    parameter int TO_WIN    = 64,
    parameter int IDX_W     = 6,
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             cmd_sent,
    input  logic             drv_en,
    input  logic             drv_val,
    input  logic             line_in,
    input  logic [IDX_W-1:0] exp_index,
    input  logic             long_resp,
    input  logic             crc_match,
    output logic             err_timeout,
    output logic             err_crc,
    output logic             err_endbit,
    output logic             err_index,
    output logic             err_conflict,
    output logic             abort_req
);
    localparam int POS_W = $clog2(LONG_LEN);
    localparam logic [POS_W-1:0] HEAD_LAST  = POS_W'(IDX_W + 1);
    localparam logic [POS_W-1:0] SHORT_PEN  = POS_W'(SHORT_LEN - 2);
    localparam logic [POS_W-1:0] LONG_PEN   = POS_W'(LONG_LEN - 2);

    ccr_state_e   state_q, state_d;
    ccr_verdict_t verdict_q;
    logic [IDX_W-1:0] idx_exp_q;
    logic             long_q;

    logic             hit, expire, start_seen;
    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] idx_rx;
    logic             trans_rx;
    logic             in_rx;
    logic [POS_W-1:0] pen_pos;

    assign start_seen = smp_en && !drv_en && !line_in;
    assign in_rx      = (state_q == CCR_HEAD) || (state_q == CCR_BODY) ||
                        (state_q == CCR_TAIL);
    assign pen_pos    = long_q ? LONG_PEN : SHORT_PEN;

    ccr_conflict_mon u_conflict (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_en  (smp_en),
        .flush   (hit),
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .line_in (line_in),
        .hit     (hit)
    );

    ccr_start_wdog #(.WIN(TO_WIN)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    ((state_q != CCR_WAIT) || cmd_sent),
        .tick   (smp_en && (state_q == CCR_WAIT)),
        .expire (expire)
    );

    ccr_field_cap #(.IDX_W(IDX_W), .POS_W(POS_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((state_q == CCR_WAIT) && start_seen),
        .tick      (smp_en && in_rx),
        .bit_in    (line_in),
        .pos       (pos),
        .idx       (idx_rx),
        .trans_bit (trans_rx)
    );

    // Command context latched at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_exp_q <= '0;
            long_q    <= 1'b0;
        end else if (cmd_sent) begin
            idx_exp_q <= exp_index;
            long_q    <= long_resp;
        end
    end

    // Verdict captured with the end bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else if ((state_q == CCR_TAIL) && smp_en) begin
            verdict_q.endbit <= ~line_in;
            verdict_q.crc    <= ~crc_match;
            verdict_q.index  <= trans_rx | (!long_q && (idx_rx != idx_exp_q));
        end
    end

    // Next-state logic: abort beats issue, issue beats everything else.
    always_comb begin
        state_d = state_q;
        if (hit) begin
            state_d = CCR_IDLE;
        end else if (cmd_sent) begin
            state_d = CCR_WAIT;
        end else begin
            unique case (state_q)
                CCR_IDLE:   state_d = CCR_IDLE;
                CCR_WAIT: begin
                    if (start_seen)  state_d = CCR_HEAD;
                    else if (expire) state_d = CCR_IDLE;
                end
                CCR_HEAD:   if (smp_en && pos == HEAD_LAST) state_d = CCR_BODY;
                CCR_BODY:   if (smp_en && pos == pen_pos)   state_d = CCR_TAIL;
                CCR_TAIL:   if (smp_en)                      state_d = CCR_REPORT;
                CCR_REPORT: state_d = CCR_IDLE;
                default:    state_d = CCR_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CCR_IDLE;
        else        state_q <= state_d;
    end

    // Registered output pulses, same priority as the transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_timeout  <= 1'b0;
            err_crc      <= 1'b0;
            err_endbit   <= 1'b0;
            err_index    <= 1'b0;
            err_conflict <= 1'b0;
            abort_req    <= 1'b0;
        end else begin
            err_timeout  <= 1'b0;
            err_crc      <= 1'b0;
            err_endbit   <= 1'b0;
            err_index    <= 1'b0;
            err_conflict <= 1'b0;
            abort_req    <= 1'b0;
            if (hit) begin
                err_timeout  <= 1'b1;
                err_crc      <= 1'b1;
                err_conflict <= 1'b1;
                abort_req    <= 1'b1;
            end else if (!cmd_sent) begin
                if ((state_q == CCR_WAIT) && expire && !start_seen) begin
                    err_timeout <= 1'b1;
                end else if (state_q == CCR_REPORT) begin
                    err_crc    <= verdict_q.crc;
                    err_endbit <= verdict_q.endbit;
                    err_index  <= verdict_q.index;
                end
            end
        end
    end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       err_timeout,
    input logic       err_crc,
    input logic       err_endbit,
    input logic       err_index,
    input logic       err_conflict,
    input logic       abort_req,
    input ccr_state_e state_q
);
    assert_conflict_joint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_conflict |-> (err_timeout && err_crc && abort_req));

    assert_abort_only_conflict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> err_conflict);

    assert_conflict_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_conflict |-> (state_q == CCR_IDLE));

    assert_crc_not_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc && !err_conflict) |-> !err_timeout);

    assert_timeout_from_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !err_conflict) |-> ($past(state_q) == CCR_WAIT));

    assert_endbit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_endbit |=> !err_endbit);

    assert_index_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_index |=> !err_index);

    assert_report_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_endbit || err_index) |-> (state_q == CCR_IDLE));
endmodule

bind cmd_resp_checker ccr_checker u_ccr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_timeout  (err_timeout),
    .err_crc      (err_crc),
    .err_endbit   (err_endbit),
    .err_index    (err_index),
    .err_conflict (err_conflict),
    .abort_req    (abort_req),
    .state_q      (state_q)
);

// File: tb/cmd_resp_checker_bench.sv
module cmd_resp_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0, cmd_sent = 1'b0;
    logic       drv_en = 1'b0, drv_val = 1'b0, line_in = 1'b1;
    logic [5:0] exp_index = '0;
    logic       long_resp = 1'b0, crc_match = 1'b1;
    logic       err_timeout, err_crc, err_endbit, err_index, err_conflict, abort_req;

    int tests = 0, fails = 0;
    int n_to = 0, n_crc = 0, n_end = 0, n_idx = 0, n_cf = 0, n_ab = 0, n_joint = 0;
    int n_wide = 0;
    logic p_to = 0, p_crc = 0, p_end = 0, p_idx = 0, p_cf = 0;

    always #10 clk = ~clk;

    cmd_resp_checker u_cmd_resp_checker (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .cmd_sent(cmd_sent),
        .drv_en(drv_en), .drv_val(drv_val), .line_in(line_in),
        .exp_index(exp_index), .long_resp(long_resp), .crc_match(crc_match),
        .err_timeout(err_timeout), .err_crc(err_crc), .err_endbit(err_endbit),
        .err_index(err_index), .err_conflict(err_conflict), .abort_req(abort_req)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_to  += int'(err_timeout);
            n_crc += int'(err_crc);
            n_end += int'(err_endbit);
            n_idx += int'(err_index);
            n_cf  += int'(err_conflict);
            n_ab  += int'(abort_req);
            if (err_conflict && err_timeout && err_crc && abort_req) n_joint++;
            if ((err_timeout && p_to) || (err_crc && p_crc) || (err_endbit && p_end) ||
                (err_index && p_idx) || (err_conflict && p_cf)) n_wide++;
        end
        p_to = err_timeout; p_crc = err_crc; p_end = err_endbit;
        p_idx = err_index; p_cf = err_conflict;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        n_to = 0; n_crc = 0; n_end = 0; n_idx = 0; n_cf = 0; n_ab = 0; n_joint = 0;
    endtask

    task automatic tick(input logic de, input logic dv, input logic ln);
        @(negedge clk);
        drv_en = de; drv_val = dv; line_in = ln; smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b1);
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic lng);
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        exp_index = idx; long_resp = lng; cmd_sent = 1'b1;
        @(negedge clk);
        cmd_sent = 1'b0; drv_en = 1'b0;
    endtask

    task automatic send_resp(input logic lng, input logic [5:0] idx, input logic trans,
                             input logic endv, input logic crc);
        int len;
        len = lng ? 136 : 48;
        crc_match = crc;
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, trans);
        for (int i = 5; i >= 0; i--) tick(1'b0, 1'b0, idx[i]);
        for (int p = 8; p <= len - 2; p++) tick(1'b0, 1'b0, 1'b1);
        tick(1'b0, 1'b0, endv);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset outputs", int'({err_timeout, err_crc, err_endbit, err_index,
                                      err_conflict, abort_req}), 0);
    endtask

    task automatic t_timeout();
        clr_counts();
        crc_match = 1'b0;
        send_cmd(6'h05, 1'b0);
        idle_ticks(63);
        chk("R1 no timeout before 64th enable", n_to, 0);
        idle_ticks(1);
        chk("R1 timeout after 64th enable", n_to, 1);
        chk("R4 no crc error on timed-out command", n_crc, 0);
        idle_ticks(70);
        chk("R9 single timeout then idle", n_to, 1);
        crc_match = 1'b1;
    endtask

    task automatic t_window_edge();
        clr_counts();
        send_cmd(6'h2A, 1'b0);
        idle_ticks(63);
        send_resp(1'b0, 6'h2A, 1'b0, 1'b1, 1'b1);
        chk("R1 start on 64th enable passes", n_to, 0);
        chk("R6 matching index no error", n_idx + n_end + n_crc, 0);
    endtask

    task automatic t_crc();
        clr_counts();
        send_cmd(6'h11, 1'b0);
        idle_ticks(3);
        send_resp(1'b0, 6'h11, 1'b0, 1'b1, 1'b0);
        chk("R4 crc mismatch reported", n_crc, 1);
        chk("R4 crc without timeout", n_to + n_end + n_idx, 0);
    endtask

    task automatic t_endbit();
        clr_counts();
        send_cmd(6'h11, 1'b0);
        idle_ticks(2);
        send_resp(1'b0, 6'h11, 1'b0, 1'b0, 1'b1);
        chk("R5 end bit 0 reported", n_end, 1);
        chk("R5 only end bit error", n_crc + n_idx + n_to, 0);
    endtask

    task automatic t_index();
        clr_counts();
        send_cmd(6'h11, 1'b0);
        idle_ticks(1);
        send_resp(1'b0, 6'h12, 1'b0, 1'b1, 1'b1);
        chk("R6 index mismatch reported", n_idx, 1);
        chk("R6 only index error", n_crc + n_end + n_to, 0);
    endtask

    task automatic t_long();
        clr_counts();
        send_cmd(6'h02, 1'b1);
        idle_ticks(5);
        send_resp(1'b1, 6'h3F, 1'b0, 1'b1, 1'b1);
        chk("R7 long response skips index", n_idx, 0);
        chk("R7 long response clean", n_end + n_crc + n_to, 0);
        clr_counts();
        send_cmd(6'h02, 1'b1);
        idle_ticks(5);
        send_resp(1'b1, 6'h3F, 1'b0, 1'b0, 1'b1);
        chk("R5 long end bit at bit 135", n_end, 1);
    endtask

    task automatic t_trans();
        clr_counts();
        send_cmd(6'h09, 1'b0);
        idle_ticks(2);
        send_resp(1'b0, 6'h09, 1'b1, 1'b1, 1'b1);
        chk("R8 transmission bit 1 reported", n_idx, 1);
    endtask

    task automatic t_conflict();
        clr_counts();
        tick(1'b1, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        drv_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 all four pulses together", n_joint, 1);
        chk("R2 abort once", n_ab, 1);
        idle_ticks(70);
        chk("R2 no timeout after abort", n_to, 1);
    endtask

    task automatic t_no_conflict();
        clr_counts();
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 no conflict when driving 0 or released", n_cf + n_ab + n_to, 0);
    endtask

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timeout();
        t_window_edge();
        t_crc();
        t_endbit();
        t_index();
        t_long();
        t_trans();
        t_conflict();
        t_no_conflict();
        chk("R9 pulses single cycle", n_wide, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule